// File: doc/BRIEF.md
# Two-Word Masked Interrupt Concentrator

This block gathers up to 64 level-sensitive interrupt sources into a single CPU interrupt line. Each source drives one bit of a 64-bit cause register, which is sampled from the source levels on every clock. A 64-bit enable mask picks which causes may reach the CPU. The interrupt output is a registered OR of every cause bit that is pending and enabled.

Software sees the block through a small word-wide register port. The cause and the mask are each split into a low word and a high word. The cause words can only be read. The mask words can be read and written, and each half is written on its own. A select word gives an interrupt handler a shortcut. In one read it returns the half of the cause register that holds the enabled pending sources. Bit 30 or bit 31 of that word tells the handler whether the high half also needs attention.

Some source positions are reserved: 29 to 31, 35, 51 to 55 and 61 to 63. These bits always read as zero. Positions 56 to 59 carry the four general-purpose-pin group summaries from a neighbouring block.

Top module: `irq_pair_concentrator`

## Requirements
- R1: After reset, both cause words and both mask words read zero, and `cpu_irq` is low.
- R2: One clock edge after source input n is sampled, cause bit n equals that level, so a cause bit sets and clears with its source. Reserved positions 29-31, 35, 51-55 and 61-63 always read zero. The low cause word is read at address 0 and holds bits 31:0. The high cause word is read at address 1 and holds bits 63:32.
- R3: A write to address 0 or address 1 leaves the cause register unchanged.
- R4: A write to address 2 replaces mask bits 31:0 with the write data. It leaves bits 63:32 unchanged. Address 2 reads back mask bits 31:0.
- R5: A write to address 3 replaces mask bits 63:32 with the write data. It leaves bits 31:0 unchanged. Address 3 reads back mask bits 63:32.
- R6: `cpu_irq` is a register. It is high in the cycle after the one in which the AND of cause and mask is non-zero, and low otherwise.
- R7: The select word is read at address 4. When no enabled cause bit is pending, it returns the low cause word unchanged.
- R8: When enabled pending bits exist only in bits 63:32, the select word returns the high cause word with bit 30 set.
- R9: When enabled pending bits exist in both halves, the select word returns the low cause word with bit 31 set.
- R10: When enabled pending bits exist only in bits 31:0, the select word returns the low cause word with bits 31 and 30 clear.
- R11: Addresses 5 to 7 read zero. A write to them changes neither the mask nor the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 64 | Interrupt source levels, bit n is source n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The select word is tried with four shapes of enabled pending sources: none at all, low half only, high half only, and both halves. The random source patterns are drawn so that whole halves are often zero. This makes each of the four select outcomes, and the two flag bits, occur many times. Half-mask writes are placed between other high and low writes, so that a write which spills into the wrong half shows in the readback. Sources pending while their mask bit is clear show whether `cpu_irq` truly depends on the mask and not on the cause alone.

// File: rtl/irq_pair_concentrator.sv
module irq_pair_concentrator #(
  parameter int          WORD_W   = 32,
  parameter int          ADDR_W   = 3,
  parameter logic [63:0] RSV_BITS = 64'hE0F8_0008_E000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*WORD_W-1:0] src_lvl,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                cpu_irq
);
  localparam int NSRC = 2 * WORD_W;
  localparam logic [ADDR_W-1:0] A_CAUSE_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CAUSE_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK_LO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK_HI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SELECT   = ADDR_W'(4);

  logic [NSRC-1:0]   cause, mask, pend;
  logic [WORD_W-1:0] sel_word;
  logic              pend_lo, pend_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= src_lvl & ~RSV_BITS[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_MASK_LO) mask[WORD_W-1:0]      <= reg_wdata;
      if (reg_addr == A_MASK_HI) mask[NSRC-1:WORD_W]   <= reg_wdata;
    end
  end

  assign pend    = cause & mask;
  assign pend_lo = |pend[WORD_W-1:0];
  assign pend_hi = |pend[NSRC-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= pend_lo | pend_hi;
  end

  always_comb begin
    sel_word = cause[WORD_W-1:0];
    if (pend_hi && !pend_lo) begin
      sel_word = cause[NSRC-1:WORD_W];
      sel_word[WORD_W-2] = 1'b1;
    end else if (pend_hi && pend_lo) begin
      sel_word[WORD_W-1] = 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CAUSE_LO: reg_rdata = cause[WORD_W-1:0];
      A_CAUSE_HI: reg_rdata = cause[NSRC-1:WORD_W];
      A_MASK_LO:  reg_rdata = mask[WORD_W-1:0];
      A_MASK_HI:  reg_rdata = mask[NSRC-1:WORD_W];
      A_SELECT:   reg_rdata = sel_word;
      default:    reg_rdata = '0;
    endcase
  end

  assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause & mask)) |=> cpu_irq);
  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cause & mask)) |=> !cpu_irq);
  assert_mask_lo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_MASK_LO) |=> $stable(mask[WORD_W-1:0]));
  assert_mask_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_MASK_HI) |=> $stable(mask[NSRC-1:WORD_W]));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & RSV_BITS[NSRC-1:0]) == '0);
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_word[WORD_W-1:WORD_W-2]) <= 1);
  assert_high_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi && !pend_lo) |-> sel_word[WORD_W-2] && !sel_word[WORD_W-1]);
  assert_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi && pend_lo) |-> sel_word[WORD_W-1] && !sel_word[WORD_W-2]);
endmodule

// File: tb/irq_pair_concentrator_tb_top.sv
module irq_pair_concentrator_tb_top;
  localparam logic [63:0] RSV = 64'hE0F8_0008_E000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_lvl = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_mask = '0;
  logic [63:0] m_cause = '0;

  always #2 clk = ~clk;

  irq_pair_concentrator dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] exp_sel(logic [63:0] c, logic [63:0] m);
    logic [63:0] p = c & m;
    if (p == 64'd0)           return c[31:0];
    if (p[31:0] == 32'd0)     return c[63:32] | 32'h4000_0000;
    if (p[63:32] != 32'd0)    return c[31:0] | 32'h8000_0000;
    return c[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd2) m_mask[31:0]  = d;
    if (a == 3'd3) m_mask[63:32] = d;
  endtask

  task automatic set_src(logic [63:0] s);
    @(negedge clk);
    src_lvl = s;
    m_cause = s & ~RSV;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    rd(3'd0, {tag, " R2 cause lo"}, m_cause[31:0]);
    rd(3'd1, {tag, " R2 cause hi"}, m_cause[63:32]);
    rd(3'd2, {tag, " R4 mask lo"}, m_mask[31:0]);
    rd(3'd3, {tag, " R5 mask hi"}, m_mask[63:32]);
    rd(3'd4, {tag, " R7-R10 select"}, exp_sel(m_cause, m_mask));
    chk({tag, " R6 irq"}, {31'd0, cpu_irq}, {31'd0, |(m_cause & m_mask)});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    src_lvl = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, "R1 cause lo", 32'd0);
    rd(3'd1, "R1 cause hi", 32'd0);
    rd(3'd2, "R1 mask lo", 32'd0);
    rd(3'd3, "R1 mask hi", 32'd0);
    chk("R1 irq", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1; src_lvl = '0;
    @(negedge clk);

    // R2 reserved bits read zero
    set_src(64'hFFFF_FFFF_FFFF_FFFF);
    check_all("all-ones");
    // R3 cause writes ignored
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    check_all("R3 cause-write");
    // R6 pending but masked: no irq
    chk("R6 masked irq", {31'd0, cpu_irq}, 32'd0);
    // R11 unused addresses
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd5, "R11 unused rd5", 32'd0);
    rd(3'd7, "R11 unused rd7", 32'd0);
    check_all("R11 unused-write");
    // R5 high-only, R8
    wr(3'd3, 32'h0000_0010);
    set_src(64'h0000_0010_0000_0001);
    check_all("R8 high-only");
    // R9 both halves
    wr(3'd2, 32'h0000_0001);
    check_all("R9 both");
    // R10 low only
    wr(3'd3, 32'h0);
    check_all("R10 low-only");
    // R7 none pending, R2 clear follows source
    set_src(64'h0000_0010_0000_0000);
    check_all("R7 none");
    set_src(64'h0);
    check_all("R2 cleared");

    for (int i = 0; i < 60; i++) begin
      logic [63:0] s;
      int mode;
      s = {$urandom, $urandom};
      mode = $urandom_range(0, 3);
      if (mode == 0) s[31:0] = '0;
      if (mode == 1) s[63:32] = '0;
      if ($urandom_range(0, 1) == 1) s = s & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) wr(3'd2, $urandom & $urandom);
      if ($urandom_range(0, 2) == 0) wr(3'd3, $urandom & $urandom);
      set_src(s);
      check_all($sformatf("rand%0d", i));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule